// File: doc/BRIEF.md
# Serial Transmitter with Holding Register

This block turns bytes written by a host into an asynchronous serial stream on a single output line. Each character goes out as a low start bit, eight data bits with the least significant bit first, and a high stop bit. A one-byte holding register sits in front of the shift register. The host can therefore load the next character while the current one is still on the line, and consecutive characters follow each other with no idle gap.

Bit timing comes from an external bit-clock tick. The block supports two modes. In oversampled mode one bit lasts sixteen ticks. In direct mode one bit lasts a single tick. The host controls the block with single-cycle enable, disable and load strobes. It watches two flags: one says the holding register can take a byte, and the other says nothing is held and nothing is being shifted.

The byte moves from the holding register into the shift register part way through the start bit. In oversampled mode this happens on the third tick of the start bit. In direct mode it happens on the tick that ends the start bit. The ready flag comes back only when the start bit ends. A disable that arrives before the byte moves cancels the character, so nothing is sent. A disable that arrives after the byte moves lets the character finish.

Top module: `uart_tx_hold`

## Requirements
- R1: After reset the line is high (mark), tx_rdy is 0, tx_emt is 1, and the transmitter is disabled.
- R2: A cmd_enable pulse on an idle, empty transmitter makes tx_rdy and tx_emt both 1 in the next cycle. When cmd_enable and cmd_disable arrive in the same cycle, disable wins and tx_rdy stays 0.
- R3: A load while tx_rdy is 1 captures load_data, and tx_rdy and tx_emt read 0 in the next cycle. A load while tx_rdy is 0 (disabled, or a byte already held) is ignored: the held byte is unchanged and no extra character is sent.
- R4: In oversampled mode (mode_1x = 0) the start bit begins on the first bit-clock tick after a byte is held. Each bit lasts 16 ticks. The frame is a 0 start bit, data bits 0 to 7 in that order, then a 1 stop bit.
- R5: In direct mode (mode_1x = 1) each bit of the same frame lasts exactly one tick.
- R6: tx_rdy stays 0 through the start bit and reads 1 in the cycle after the tick that ends the start bit.
- R7: A byte loaded while a frame is in progress starts its own start bit on the tick that ends the previous stop bit, with no idle gap.
- R8: A disable that arrives before the byte transfers cancels the character. In oversampled mode the transfer is the third tick of the start bit; in direct mode it is the tick that ends the start bit. In the next cycle the line is high and tx_emt is 1, and the line stays high.
- R9: A disable that arrives after the transfer lets the character in the shift register finish. Any byte in the holding register is dropped, tx_rdy stays 0, and the line stays high after the stop bit.
- R10: Whenever tx_emt is 1 the line is high. tx_emt is 1 exactly when no byte is held and no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_tick | input | 1 | Bit-clock tick, one cycle wide |
| mode_1x | input | 1 | 1 = one tick per bit, 0 = sixteen ticks per bit |
| cmd_enable | input | 1 | Enable command strobe |
| cmd_disable | input | 1 | Disable command strobe (wins over enable) |
| load | input | 1 | Load strobe for the holding register |
| load_data | input | 8 | Byte to load |
| txd | output | 1 | Serial line, high when idle |
| tx_rdy | output | 1 | Holding register can accept a byte |
| tx_emt | output | 1 | Nothing held and nothing shifting |

## Verification
The flags settle one clock after a strobe. tx_rdy and tx_emt change in the cycle after load, cmd_enable or cmd_disable, so the bench drives each strobe for one cycle and reads the flags at the following falling edge. The line and the end-of-start ready flag change one cycle after the clock edge that takes a tick. The bench issues every tick as a one-cycle pulse followed by a quiet cycle, and samples txd and tx_rdy after that, at both the first and the last tick of every bit period. The cancel and finish cases place the disable right after a chosen tick (before or after the third start-bit tick in oversampled mode, before the second tick in direct mode), so the bench knows in advance whether the transfer has happened.

// File: rtl/uth_pkg.sv
package uth_pkg;

    localparam int unsigned DATA_W     = 8;
    localparam int unsigned BITIDX_W   = $clog2(DATA_W);
    localparam int unsigned OVS_DEF    = 16;
    localparam int unsigned XFER_DEF   = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } tx_state_e;

    typedef struct packed {
        logic              enabled;
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_s;

    function automatic logic line_level(input tx_state_e st, input logic lsb);
        case (st)
            ST_START: return 1'b0;
            ST_DATA:  return lsb;
            default:  return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/uth_bit_timer.sv
module uth_bit_timer #(
    parameter int unsigned OVS        = 16,
    parameter int unsigned XFER_TICKS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic one_x,
    input  logic park,
    output logic bit_end,
    output logic xfer_pt
);
    localparam int unsigned CNT_W = (OVS > 1) ? $clog2(OVS) : 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_c;
    logic [CNT_W-1:0] xfer_c;

    assign last_c = one_x ? '0 : CNT_W'(OVS - 1);
    assign xfer_c = one_x ? '0 : CNT_W'(XFER_TICKS - 1);

    always_ff @(posedge clk) begin
        if (rst || park) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == last_c) ? '0 : cnt + 1'b1;
        end
    end

    assign bit_end = tick && (cnt == last_c);
    assign xfer_pt = tick && (cnt == xfer_c);
endmodule

// File: rtl/uth_holding.sv
module uth_holding
    import uth_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_en,
    input  logic              cmd_dis,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              start_done,
    output hold_s             hold,
    output logic              rdy
);
    assign rdy = hold.enabled && !hold.full;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
        end else if (cmd_dis) begin
            hold.enabled <= 1'b0;
            hold.full    <= 1'b0;
        end else begin
            if (cmd_en) begin
                hold.enabled <= 1'b1;
            end
            if (load && rdy) begin
                hold.full <= 1'b1;
                hold.data <= din;
            end else if (start_done) begin
                hold.full <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/uth_shifter.sv
module uth_shifter
    import uth_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      bit_end,
    input  logic      xfer_pt,
    input  logic      cmd_dis,
    input  hold_s     hold,
    output tx_state_e state,
    output logic      xfer_done,
    output logic      start_done,
    output logic      txd
);
    logic [DATA_W-1:0]   shreg;
    logic [BITIDX_W-1:0] bitn;
    logic                start_ok;
    logic                cancel;

    assign start_ok   = hold.enabled && hold.full && !cmd_dis;
    assign cancel     = (state == ST_START) && cmd_dis && !xfer_done;
    assign start_done = (state == ST_START) && bit_end && !cancel;
    assign txd        = line_level(state, shreg[0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            shreg     <= '1;
            bitn      <= '0;
            xfer_done <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_ok && tick) begin
                        state     <= ST_START;
                        xfer_done <= 1'b0;
                    end
                end
                ST_START: begin
                    if (cancel) begin
                        state <= ST_IDLE;
                    end else begin
                        if (xfer_pt && !xfer_done) begin
                            shreg     <= hold.data;
                            xfer_done <= 1'b1;
                        end
                        if (bit_end) begin
                            state <= ST_DATA;
                            bitn  <= '0;
                        end
                    end
                end
                ST_DATA: begin
                    if (bit_end) begin
                        shreg <= {1'b1, shreg[DATA_W-1:1]};
                        if (bitn == BITIDX_W'(DATA_W - 1)) begin
                            state <= ST_STOP;
                        end else begin
                            bitn <= bitn + 1'b1;
                        end
                    end
                end
                default: begin
                    if (bit_end) begin
                        if (start_ok) begin
                            state     <= ST_START;
                            xfer_done <= 1'b0;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
    import uth_pkg::*;
#(
    parameter int unsigned OVS        = OVS_DEF,
    parameter int unsigned XFER_TICKS = XFER_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bclk_tick,
    input  logic              mode_1x,
    input  logic              cmd_enable,
    input  logic              cmd_disable,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              txd,
    output logic              tx_rdy,
    output logic              tx_emt
);
    hold_s     hold;
    tx_state_e st;
    logic      xfer_done;
    logic      start_done;
    logic      bit_end;
    logic      xfer_pt;

    uth_holding u_hold (
        .clk        (clk),
        .rst        (rst),
        .cmd_en     (cmd_enable),
        .cmd_dis    (cmd_disable),
        .load       (load),
        .din        (load_data),
        .start_done (start_done),
        .hold       (hold),
        .rdy        (tx_rdy)
    );

    uth_bit_timer #(
        .OVS        (OVS),
        .XFER_TICKS (XFER_TICKS)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick    (bclk_tick),
        .one_x   (mode_1x),
        .park    (st == ST_IDLE),
        .bit_end (bit_end),
        .xfer_pt (xfer_pt)
    );

    uth_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .tick       (bclk_tick),
        .bit_end    (bit_end),
        .xfer_pt    (xfer_pt),
        .cmd_dis    (cmd_disable),
        .hold       (hold),
        .state      (st),
        .xfer_done  (xfer_done),
        .start_done (start_done),
        .txd        (txd)
    );

    assign tx_emt = (st == ST_IDLE) && !hold.full;
endmodule

// File: rtl/uth_checker.sv
module uth_checker
    import uth_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      cmd_enable,
    input logic      cmd_disable,
    input logic      load,
    input logic      txd,
    input logic      tx_rdy,
    input logic      tx_emt,
    input tx_state_e st,
    input logic      xfer_done
);
    a_r10_empty_line_high: assert property (@(posedge clk) disable iff (rst)
        tx_emt |-> txd);

    a_r3_rdy_falls_on_load: assert property (@(posedge clk) disable iff (rst)
        (load && tx_rdy) |=> !tx_rdy);

    a_r9_disable_drops_rdy: assert property (@(posedge clk) disable iff (rst)
        cmd_disable |=> !tx_rdy);

    a_r2_enable_when_empty: assert property (@(posedge clk) disable iff (rst)
        (cmd_enable && !cmd_disable && !load && tx_emt) |=> (tx_rdy && tx_emt));

    a_r8_cancel_before_xfer: assert property (@(posedge clk) disable iff (rst)
        (cmd_disable && st == ST_START && !xfer_done) |=> (txd && tx_emt));
endmodule

bind uart_tx_hold uth_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_enable  (cmd_enable),
    .cmd_disable (cmd_disable),
    .load        (load),
    .txd         (txd),
    .tx_rdy      (tx_rdy),
    .tx_emt      (tx_emt),
    .st          (st),
    .xfer_done   (xfer_done)
);

// File: tb/sim_uart_tx_hold.sv
`timescale 1ns/1ps
module sim_uart_tx_hold;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bclk_tick = 1'b0;
    logic       mode_1x = 1'b0;
    logic       cmd_enable = 1'b0;
    logic       cmd_disable = 1'b0;
    logic       load = 1'b0;
    logic [7:0] load_data = 8'h00;
    logic       txd;
    logic       tx_rdy;
    logic       tx_emt;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;

    uart_tx_hold u0 (
        .clk(clk), .rst(rst), .bclk_tick(bclk_tick), .mode_1x(mode_1x),
        .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .load(load),
        .load_data(load_data), .txd(txd), .tx_rdy(tx_rdy), .tx_emt(tx_emt)
    );

    // each vector: {mode_1x, byte}
    localparam logic [8:0] VEC [6] = '{
        {1'b0, 8'hA5}, {1'b1, 8'h3C}, {1'b0, 8'h00},
        {1'b1, 8'hFF}, {1'b0, 8'h81}, {1'b1, 8'h5A}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tick_step();
        bclk_tick = 1'b1;
        idle_cycle();
        bclk_tick = 1'b0;
        idle_cycle();
    endtask

    task automatic load_byte(input logic [7:0] b);
        load = 1'b1;
        load_data = b;
        idle_cycle();
        load = 1'b0;
    endtask

    task automatic pulse_enable();
        cmd_enable = 1'b1;
        idle_cycle();
        cmd_enable = 1'b0;
    endtask

    task automatic pulse_disable();
        cmd_disable = 1'b1;
        idle_cycle();
        cmd_disable = 1'b0;
    endtask

    task automatic run_frame(input int per, input logic [7:0] nxt, input bit nxt_v,
                             input int dis_at, output logic [7:0] got, output bit ok,
                             output logic rdy_pre, output logic rdy_post);
        got = 8'h00;
        ok = 1'b1;
        rdy_pre = 1'b1;
        rdy_post = 1'b0;
        for (int t = 0; t < 10 * per; t++) begin
            int b;
            tick_step();
            b = t / per;
            if ((t % per == 0) || (t % per == per - 1)) begin
                if (b == 0) ok &= (txd == 1'b0);
                else if (b == 9) ok &= (txd == 1'b1);
                else if (t % per == 0) got[b-1] = txd;
                else ok &= (txd == got[b-1]);
            end
            if (t == per - 1) rdy_pre = tx_rdy;
            if (t == per) rdy_post = tx_rdy;
            if (t == per && nxt_v) load_byte(nxt);
            if (t == dis_at) pulse_disable();
        end
    endtask

    task automatic quiet_ticks(input int n, output bit stayed_high);
        stayed_high = 1'b1;
        for (int k = 0; k < n; k++) begin
            tick_step();
            stayed_high &= (txd == 1'b1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0] got;
        bit         ok;
        bit         high;
        logic       rp;
        logic       rq;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 txd", txd, 1);
        check("R1 tx_rdy", tx_rdy, 0);
        check("R1 tx_emt", tx_emt, 1);

        // R2 disable wins over simultaneous enable
        cmd_enable = 1'b1;
        cmd_disable = 1'b1;
        idle_cycle();
        cmd_enable = 1'b0;
        cmd_disable = 1'b0;
        check("R2 priority rdy", tx_rdy, 0);

        // R3 load while disabled ignored
        load_byte(8'h55);
        check("R3 disabled load emt", tx_emt, 1);
        quiet_ticks(20, high);
        check("R3 disabled load line", high, 1);

        // R2 enable
        pulse_enable();
        check("R2 enable rdy", tx_rdy, 1);
        check("R2 enable emt", tx_emt, 1);

        // R4 R5 R6 vector table
        for (int i = 0; i < 6; i++) begin
            int per;
            mode_1x = VEC[i][8];
            per = VEC[i][8] ? 1 : 16;
            load_byte(VEC[i][7:0]);
            check("R3 rdy after load", tx_rdy, 0);
            check("R3 emt after load", tx_emt, 0);
            run_frame(per, 8'h00, 1'b0, -1, got, ok, rp, rq);
            check(VEC[i][8] ? "R5 data" : "R4 data", got, VEC[i][7:0]);
            check(VEC[i][8] ? "R5 framing" : "R4 framing", ok, 1);
            check("R6 rdy low in start", rp, 0);
            check("R6 rdy high after start", rq, 1);
            tick_step();
            check("R10 emt after frame", tx_emt, 1);
            check("R10 line after frame", txd, 1);
        end

        // R7 back-to-back in 16x
        mode_1x = 1'b0;
        load_byte(8'h3D);
        run_frame(16, 8'h96, 1'b1, -1, got, ok, rp, rq);
        check("R7 first byte", got, 8'h3D);
        run_frame(16, 8'h00, 1'b0, -1, got, ok, rp, rq);
        check("R7 second byte", got, 8'h96);
        check("R7 second framing", ok, 1);
        tick_step();
        check("R10 emt after pair", tx_emt, 1);

        // R3 load while holding full ignored
        load_byte(8'h12);
        load_byte(8'hEE);
        run_frame(16, 8'h00, 1'b0, -1, got, ok, rp, rq);
        check("R3 held byte kept", got, 8'h12);
        tick_step();
        check("R3 no extra frame emt", tx_emt, 1);
        quiet_ticks(40, high);
        check("R3 no extra frame line", high, 1);

        // R8 cancel in 16x before third tick
        load_byte(8'h77);
        tick_step();
        tick_step();
        tick_step();
        check("R8 start in progress", txd, 0);
        pulse_disable();
        check("R8 16x line", txd, 1);
        check("R8 16x emt", tx_emt, 1);
        check("R8 16x rdy", tx_rdy, 0);
        quiet_ticks(40, high);
        check("R8 16x stays high", high, 1);

        // R8 cancel in 1x before the tick ending start
        pulse_enable();
        mode_1x = 1'b1;
        load_byte(8'h44);
        tick_step();
        check("R8 1x start bit", txd, 0);
        pulse_disable();
        check("R8 1x line", txd, 1);
        check("R8 1x emt", tx_emt, 1);
        quiet_ticks(12, high);
        check("R8 1x stays high", high, 1);

        // R9 disable after transfer in 16x: character completes
        pulse_enable();
        mode_1x = 1'b0;
        load_byte(8'hC3);
        run_frame(16, 8'h00, 1'b0, 3, got, ok, rp, rq);
        check("R9 finished byte", got, 8'hC3);
        check("R9 finished framing", ok, 1);
        check("R9 rdy stays low", rq, 0);
        tick_step();
        check("R9 emt after finish", tx_emt, 1);

        // R9 held next byte dropped on disable, 1x
        pulse_enable();
        mode_1x = 1'b1;
        load_byte(8'h0F);
        run_frame(1, 8'hF0, 1'b1, 5, got, ok, rp, rq);
        check("R9 current byte", got, 8'h0F);
        quiet_ticks(12, high);
        check("R9 held byte dropped", high, 1);
        check("R9 emt after drop", tx_emt, 1);
        check("R9 rdy while disabled", tx_rdy, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule